// File: doc/BRIEF.md
# PCI Memory Target Burst Address Tracker

This block sits inside a PCI memory target, next to the bus interface state machine. On the clock where the address-phase strobe is high, it takes the address from the shared 32-bit address/data bus. It checks the bus command and compares the dword part of the address against the device's memory window. The window is given by a byte base and a byte size. The two lowest address bits are not treated as byte address bits. They select the burst ordering. Only the linear-incrementing order is accepted.

After the address phase, the tracker presents the current dword address to the data path. It moves that address on by one dword on each clock where a data transfer completes, and holds it through wait states. The hit flag tells the target state machine whether it still claims the current data phase. The flag drops in three cases: when the command is not a memory command, when the burst runs past the end of the window, and after the first data phase of a burst whose order is not supported. A separate flag reports the unsupported order so that the target can disconnect.

Top module: `pci_burst_addr_trk`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `hit_o`, `bad_order_o` and `dw_addr_o` are all zero.
- R2: On a clock where `addr_phase_i` is high, `dw_addr_o` takes `ad_i[31:2]`. The new value is visible from the next cycle.
- R3: Only the memory command codes 4'h6, 4'h7, 4'hC, 4'hE and 4'hF on `cmd_i` can produce a hit. All other codes, including I/O (4'h2/4'h3), configuration (4'hA/4'hB) and special (4'h1), leave `hit_o` low for the whole transaction.
- R4: A memory address phase gives `hit_o`=1 in the next cycle exactly when `win_base_i[31:2]` <= `ad_i[31:2]` < `win_base_i[31:2]` + `win_size_i[31:2]`. This comparison does not wrap past the top of the address space.
- R5: During a transaction, a clock with `xfer_i`=1 and `last_i`=0 advances `dw_addr_o` by one dword (4 bytes).
- R6: During a transaction, a clock with `xfer_i`=0 and `addr_phase_i`=0 (a wait state) leaves `dw_addr_o`, `hit_o` and `bad_order_o` unchanged.
- R7: For a memory command, `ad_i[1:0]`=2'b00 means linear increment and gives `bad_order_o`=0. Any other value sets `bad_order_o`=1 from the next cycle until the transaction ends. Non-memory commands never set it.
- R8: For an unsupported burst order, `hit_o` goes low on the clock after the first completed data phase.
- R9: When an advance moves `dw_addr_o` out of the window, `hit_o` is already low in the cycle that shows the out-of-range address.
- R10: A clock with `xfer_i`=1 and `last_i`=1 ends the transaction. `hit_o` and `bad_order_o` go to 0, and `dw_addr_o` holds its value.
- R11: When `addr_phase_i` and `xfer_i` are both high on the same clock, the address phase wins and the transfer strobe is ignored.
- R12: `xfer_i` has no effect when no transaction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Multiplexed address/data bus |
| cmd_i | input | 4 | Bus command, sampled in the address phase |
| addr_phase_i | input | 1 | High on the clock of an address phase |
| xfer_i | input | 1 | High on a clock where a data phase completes |
| last_i | input | 1 | Marks the completing data phase as the final one |
| win_base_i | input | 32 | Byte base of the memory window |
| win_size_i | input | 32 | Byte size of the memory window |
| hit_o | output | 1 | Target claims the current data phase |
| dw_addr_o | output | 30 | Current dword address |
| bad_order_o | output | 1 | Unsupported burst ordering seen |

## Verification
A new address capture and a data-phase advance can fall on the same clock. This happens when one transaction ends and the next address phase arrives while a transfer strobe is still high. The bench provokes it by raising `addr_phase_i` and `xfer_i` together in the middle of a burst. It judges the result by requiring that the next cycle shows the new captured address, with a hit and order status that come from the new command alone, and not the old address plus one. A second same-cycle case is an advance that both completes a data phase and steps past the window end. The bench checks this at the last dword of a window that ends at the top of the address space.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

    typedef enum logic [2:0] {
        KIND_OTHER   = 3'd0,
        KIND_IO      = 3'd1,
        KIND_MEM     = 3'd2,
        KIND_CFG     = 3'd3,
        KIND_SPECIAL = 3'd4
    } cmd_kind_t;

    localparam logic [1:0] ORD_LINEAR = 2'b00;

    localparam int CMD_W = 4;

endpackage

// File: rtl/pbt_cmd_decode.sv
module pbt_cmd_decode
    import pbt_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_kind_t        kind_o,
    output logic             is_mem_o
);

    always_comb begin
        unique case (cmd_i)
            4'h2, 4'h3:                   kind_o = KIND_IO;
            4'h6, 4'h7, 4'hC, 4'hE, 4'hF: kind_o = KIND_MEM;
            4'hA, 4'hB:                   kind_o = KIND_CFG;
            4'h1:                         kind_o = KIND_SPECIAL;
            default:                      kind_o = KIND_OTHER;
        endcase
    end

    assign is_mem_o = (kind_o == KIND_MEM);

endmodule

// File: rtl/pbt_order_class.sv
module pbt_order_class
    import pbt_pkg::*;
(
    input  logic [1:0] ord_i,
    input  logic       is_mem_i,
    output logic       linear_o,
    output logic       bad_o
);

    // Order bits only carry meaning for memory commands.
    assign linear_o = (ord_i == ORD_LINEAR);
    assign bad_o    = is_mem_i && !linear_o;

endmodule

// File: rtl/pbt_win_cmp.sv
module pbt_win_cmp #(
    parameter int DWA_W = 30
) (
    input  logic [DWA_W-1:0] dw_i,
    input  logic [DWA_W-1:0] base_dw_i,
    input  logic [DWA_W-1:0] size_dw_i,
    output logic             inside_o
);

    logic [DWA_W-1:0] offset;
    logic             at_or_above;

    always_comb begin
        at_or_above = (dw_i >= base_dw_i);
        offset      = dw_i - base_dw_i;
        inside_o    = at_or_above && (offset < size_dw_i);
    end

endmodule

// File: rtl/pci_burst_addr_trk.sv
module pci_burst_addr_trk
    import pbt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ad_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              addr_phase_i,
    input  logic              xfer_i,
    input  logic              last_i,
    input  logic [AW-1:0]     win_base_i,
    input  logic [AW-1:0]     win_size_i,
    output logic              hit_o,
    output logic [AW-3:0]     dw_addr_o,
    output logic              bad_order_o
);

    localparam int DWA_W = AW - 2;
    localparam int N_CMP = 2;
    localparam int CMP_CAP = 0;
    localparam int CMP_NXT = 1;

    typedef struct packed {
        logic             active;
        logic             mem;
        logic             linear;
        logic             hit;
        logic             bad;
        logic [DWA_W-1:0] addr;
    } trk_state_t;

    trk_state_t st_d, st_q;

    cmd_kind_t        cmd_kind;
    logic             cmd_is_mem;
    logic             ord_linear;
    logic             ord_bad;
    logic [DWA_W-1:0] addr_nxt;
    logic [DWA_W-1:0] base_dw;
    logic [DWA_W-1:0] size_dw;
    logic [DWA_W-1:0] cmp_addr [N_CMP];
    logic [N_CMP-1:0] in_win;

    pbt_cmd_decode u_dec (
        .cmd_i    (cmd_i),
        .kind_o   (cmd_kind),
        .is_mem_o (cmd_is_mem)
    );

    pbt_order_class u_ord (
        .ord_i    (ad_i[1:0]),
        .is_mem_i (cmd_is_mem),
        .linear_o (ord_linear),
        .bad_o    (ord_bad)
    );

    assign base_dw  = win_base_i[AW-1:2];
    assign size_dw  = win_size_i[AW-1:2];
    assign addr_nxt = st_q.addr + DWA_W'(1);

    assign cmp_addr[CMP_CAP] = ad_i[AW-1:2];
    assign cmp_addr[CMP_NXT] = addr_nxt;

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        pbt_win_cmp #(.DWA_W(DWA_W)) u_cmp (
            .dw_i      (cmp_addr[g]),
            .base_dw_i (base_dw),
            .size_dw_i (size_dw),
            .inside_o  (in_win[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (addr_phase_i) begin
            st_d.active = 1'b1;
            st_d.addr   = ad_i[AW-1:2];
            st_d.mem    = cmd_is_mem;
            st_d.linear = ord_linear;
            st_d.hit    = cmd_is_mem && in_win[CMP_CAP];
            st_d.bad    = ord_bad;
        end else if (st_q.active && xfer_i) begin
            if (last_i) begin
                st_d.active = 1'b0;
                st_d.hit    = 1'b0;
                st_d.bad    = 1'b0;
            end else begin
                st_d.addr = addr_nxt;
                st_d.hit  = st_q.mem && st_q.linear && in_win[CMP_NXT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o       = st_q.hit;
    assign dw_addr_o   = st_q.addr;
    assign bad_order_o = st_q.bad;

    logic unused_kind;
    assign unused_kind = ^cmd_kind;

endmodule

// File: rtl/pbt_chk.sv
module pbt_chk
    import pbt_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     ad_i,
    input logic [CMD_W-1:0]  cmd_i,
    input logic              addr_phase_i,
    input logic              xfer_i,
    input logic              last_i,
    input logic [AW-1:0]     win_base_i,
    input logic [AW-1:0]     win_size_i,
    input logic              hit_o,
    input logic [AW-3:0]     dw_addr_o,
    input logic              bad_order_o
);

    logic mem_cmd;
    assign mem_cmd = cmd_i inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};

    // R2
    capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase_i |=> dw_addr_o == $past(ad_i[AW-1:2]));

    // R3
    non_mem_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase_i && !mem_cmd) |=> (!hit_o && !bad_order_o));

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase_i && xfer_i && !last_i && hit_o) |=> dw_addr_o == $past(dw_addr_o) + 1'b1);

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase_i && !xfer_i) |=> ($stable(dw_addr_o) && $stable(hit_o) && $stable(bad_order_o)));

    // R7
    bad_order_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase_i && mem_cmd && ad_i[1:0] != 2'b00) |=> bad_order_o);

    // R8
    bad_order_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_order_o && xfer_i && !addr_phase_i) |=> !hit_o);

    // R10
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase_i && xfer_i && last_i && hit_o) |=> (!hit_o && !bad_order_o && $stable(dw_addr_o)));

endmodule

bind pci_burst_addr_trk pbt_chk #(.AW(AW)) u_chk (.*);

// File: tb/pci_burst_addr_trk_tb_top.sv
module pci_burst_addr_trk_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cmd_i = '0;
    logic        addr_phase_i = 1'b0;
    logic        xfer_i = 1'b0;
    logic        last_i = 1'b0;
    logic [31:0] win_base_i = 32'h0000_1000;
    logic [31:0] win_size_i = 32'h0000_0100;
    logic        hit_o;
    logic [29:0] dw_addr_o;
    logic        bad_order_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_burst_addr_trk dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cmd_i(cmd_i),
        .addr_phase_i(addr_phase_i), .xfer_i(xfer_i), .last_i(last_i),
        .win_base_i(win_base_i), .win_size_i(win_size_i),
        .hit_o(hit_o), .dw_addr_o(dw_addr_o), .bad_order_o(bad_order_o)
    );

    typedef struct {
        logic        hit;
        logic [29:0] addr;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Bench model state, from the requirements
    logic        m_act = 0, m_mem = 0, m_lin = 0, m_hit = 0, m_bad = 0;
    logic [29:0] m_addr = '0;

    function automatic logic is_mem(input logic [3:0] c);
        return c inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
    endfunction

    function automatic logic in_win(input logic [29:0] a);
        logic [30:0] lo, hi;
        lo = {1'b0, win_base_i[31:2]};
        hi = lo + {1'b0, win_size_i[31:2]};
        return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
    endfunction

    task automatic step(input logic ap, input logic xf, input logic lst,
                        input logic [31:0] ad, input logic [3:0] cmd, input string tag);
        exp_t e;
        @(negedge clk);
        addr_phase_i = ap; xfer_i = xf; last_i = lst; ad_i = ad; cmd_i = cmd;
        if (ap) begin
            m_act = 1; m_addr = ad[31:2]; m_mem = is_mem(cmd); m_lin = (ad[1:0] == 2'b00);
            m_hit = m_mem && in_win(m_addr); m_bad = m_mem && !m_lin;
        end else if (m_act && xf) begin
            if (lst) begin
                m_act = 0; m_hit = 0; m_bad = 0;
            end else begin
                m_addr = m_addr + 30'd1;
                m_hit = m_mem && m_lin && in_win(m_addr);
            end
        end
        e.hit = m_hit; e.addr = m_addr; e.bad = m_bad; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'h0, tag);
    endtask

    // Monitor: compares one expected item after each clock that has one queued
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (hit_o !== e.hit || dw_addr_o !== e.addr || bad_order_o !== e.bad) begin
                errors++;
                $display("FAIL %s: got hit=%0b addr=%h bad=%0b, expected hit=%0b addr=%h bad=%0b",
                         e.tag, hit_o, dw_addr_o, bad_order_o, e.hit, e.addr, e.bad);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (hit_o !== 1'b0 || dw_addr_o !== '0 || bad_order_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got hit=%0b addr=%h bad=%0b, expected 0 0 0", hit_o, dw_addr_o, bad_order_o);
        end
        rst_n = 1'b1;
        idle("R1 first cycle after reset");

        // R12: transfer strobe while idle
        step(0, 1, 0, 32'h0, 4'h0, "R12 xfer ignored while idle");

        // R2 R4: memory read in window
        step(1, 0, 0, 32'h0000_1000, 4'h6, "R2 R4 capture in window");
        idle("R6 wait state holds");
        step(0, 1, 0, 32'h0, 4'h0, "R5 advance one dword");
        step(0, 1, 0, 32'h0, 4'h0, "R5 advance again");
        idle("R6 wait state holds mid burst");
        step(0, 1, 1, 32'h0, 4'h0, "R10 last data phase ends");
        step(0, 1, 0, 32'h0, 4'h0, "R12 xfer after end ignored");

        // R9: burst crosses window end
        step(1, 0, 0, 32'h0000_10F8, 4'h7, "R4 near window end");
        step(0, 1, 0, 32'h0, 4'h0, "R9 last dword in window");
        step(0, 1, 0, 32'h0, 4'h0, "R9 beyond window drops hit");
        step(0, 1, 1, 32'h0, 4'h0, "R10 end after cross");

        // R4: below base and at end
        step(1, 0, 0, 32'h0000_0FFC, 4'hC, "R4 below base misses");
        step(1, 0, 0, 32'h0000_1100, 4'hE, "R4 at window end misses");
        step(1, 0, 0, 32'h0000_10FC, 4'hF, "R3 R4 write-invalidate last dword hits");

        // R3: non-memory commands never hit
        step(1, 0, 0, 32'h0000_1001, 4'h2, "R3 R7 I/O read no hit no flag");
        step(1, 0, 0, 32'h0000_1004, 4'hA, "R3 config read no hit");
        step(1, 0, 0, 32'h0000_1008, 4'h1, "R3 special no hit");
        step(1, 0, 0, 32'h0000_1010, 4'h0, "R3 other code no hit");

        // R7 R8: unsupported order
        step(1, 0, 0, 32'h0000_1012, 4'h6, "R7 toggle order flagged");
        idle("R6 R7 wait keeps flag");
        step(0, 1, 0, 32'h0, 4'h0, "R8 hit drops after first data phase");
        step(0, 1, 1, 32'h0, 4'h0, "R10 end clears flag");
        step(1, 0, 0, 32'h0000_1023, 4'h7, "R7 order 11 flagged");
        step(1, 0, 0, 32'h0000_1020, 4'h7, "R7 linear order clears flag");

        // R11: address phase and transfer on the same clock
        step(0, 1, 0, 32'h0, 4'h0, "R5 advance before overlap");
        step(1, 1, 0, 32'h0000_1040, 4'h6, "R11 address phase wins over xfer");
        step(1, 1, 1, 32'h0000_1082, 4'hC, "R11 address phase wins over last");
        step(0, 1, 1, 32'h0, 4'h0, "R10 end");

        // R9: window at top of address space
        win_base_i = 32'hFFFF_FF00;
        step(1, 0, 0, 32'hFFFF_FFFC, 4'h6, "R4 top window last dword");
        step(0, 1, 0, 32'h0, 4'h0, "R9 wrap past top drops hit");
        step(0, 1, 1, 32'h0, 4'h0, "R10 end");

        idle("R6 idle settle");
        idle("R6 idle settle 2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule